// File: doc/BRIEF.md
# Periodic Burst Transmission Scheduler

This block decides when a low-power transmitter sends a packet. A period timer counts a slow time-base tick. Each time the programmed period ends, the block starts a burst. A burst is one packet plus up to three repeats of it. Before each packet the block asks the ADCs for the conversions the configuration selects. It waits until every requested conversion is done, then pulses a transmit start. It waits for the modem's transmit-done before it does anything more in that burst.

Repeats inside a burst are not spaced evenly. Each gap is a pseudo-random number of ticks taken from a 16-bit LFSR, which is seeded from the chip identifier. Transmitters that share a channel therefore drift apart. The period itself is never randomized. The block also holds three payload flags steady for the whole burst, and a downstream packet assembler reads them to decide what to put in the packet.

Configuration byte layout:
- bit 0: resolution (1 = coarse unit, 0 = fine unit)
- bit 1: external ADC data
- bit 2: internal ADC data
- bit 3: chip identifier in payload
- bits 5:4: repeat count
- bits 7:6: unused

Top module: `burst_scheduler`

## Requirements
- R1: A synchronous active-low reset clears `tx_start_o`, both ADC requests and all payload flags. Reset loads the LFSR from `chip_id_i` and starts a fresh period.
- R2: With `cfg_i[0]`=0, one unit is one `tick_i`. The first burst starts on tick number (`ival_i`+1) after reset, so an interval byte of 0 gives one tick.
- R3: With `cfg_i[0]`=1, one unit is COARSE_RATIO ticks (default 300, which is 15 s of 50 ms ticks). The period is (`ival_i`+1)*COARSE_RATIO ticks.
- R4: The repeat field `cfg_i[5:4]`=n gives n+1 transmit start pulses per burst.
- R5: The LFSR shifts right. When the bit shifted out is 1, the new value is XORed with 16'hB400. The reset seed is `chip_id_i`, or 16'hACE1 when `chip_id_i` is zero. After a transmit-done that has a repeat still to come, the gap is (LFSR[3:0]+1) ticks and the LFSR then advances once. The repeat's activity starts on the last tick of the gap.
- R6: `adc_int_req_o` follows `cfg_i[2]` and `adc_ext_req_o` follows `cfg_i[1]`. Each request stays high until its own done input pulses. No transmit start is issued while any requested conversion is still outstanding.
- R7: `tx_start_o` is a one-cycle pulse. The block waits for `tx_done_i` after each start, and ticks that arrive during that wait start nothing.
- R8: `pl_chip_id_o`, `pl_int_adc_o` and `pl_ext_adc_o` equal `cfg_i[3]`, `cfg_i[2]` and `cfg_i[1]` as captured when the burst starts. They hold for the whole burst.
- R9: The period timer reloads itself at each expiry, whether or not a burst is running. An expiry during a burst is kept pending, and a new burst starts as soon as the current one ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_i | input | 8 | Burst configuration byte (layout above) |
| ival_i | input | 8 | Interval byte; period = value+1 units |
| chip_id_i | input | 16 | Chip identifier, used as the LFSR seed |
| tick_i | input | 1 | Fine time-base tick, one clock wide |
| adc_int_done_i | input | 1 | Internal (battery and temperature) conversion done pulse |
| adc_ext_done_i | input | 1 | External two-channel conversion done pulse |
| tx_done_i | input | 1 | Transmitter finished pulse |
| adc_int_req_o | output | 1 | Request for internal conversions |
| adc_ext_req_o | output | 1 | Request for external conversions |
| tx_start_o | output | 1 | One-cycle transmit start |
| pl_chip_id_o | output | 1 | Payload carries the chip identifier |
| pl_int_adc_o | output | 1 | Payload carries internal ADC data |
| pl_ext_adc_o | output | 1 | Payload carries external ADC data |

## Verification
The assertions check on every cycle the properties that hold cycle by cycle:
- the start is a single-cycle pulse;
- no start is issued while a requested conversion is outstanding;
- the LFSR never reaches zero;
- gap counts stay in range;
- the repeat count steps down one at a time;
- payload flags hold during a burst;
- an expiry during a burst is kept as pending.

Only the bench scenarios can show the quantities that span many ticks: the exact period in fine and coarse units, the number of transmissions per burst, the gap lengths that follow from the seeded LFSR sequence, and a pending burst starting right after the previous burst ends.

// File: rtl/burst_pkg.sv
// Shared definitions for the burst scheduler.
// Assumes the configuration byte layout stated in the brief.
package burst_pkg;
    typedef enum logic [2:0] {
        S_IDLE  = 3'd0,
        S_ADC   = 3'd1,
        S_START = 3'd2,
        S_TXW   = 3'd3,
        S_GAP   = 3'd4
    } seq_state_t;

    localparam int          LFSR_W    = 16;
    localparam logic [15:0] LFSR_TAPS = 16'hB400;
    localparam logic [15:0] LFSR_ALT  = 16'hACE1;

    localparam int CF_RES    = 0;
    localparam int CF_EXT    = 1;
    localparam int CF_INT    = 2;
    localparam int CF_ID     = 3;
    localparam int CF_REP_LO = 4;
    localparam int REP_W     = 2;
endpackage

// File: rtl/burst_period_timer.sv
// Fixed cyclic period timer. It counts (ival+1) units, where one unit is
// one tick (fine) or COARSE_RATIO ticks (coarse). It reloads itself at
// each expiry. Assumes tick_i is one clock wide.
module burst_period_timer #(
    parameter int COARSE_RATIO = 300,
    parameter int IVAL_W       = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              coarse_i,
    input  logic [IVAL_W-1:0] ival_i,
    output logic              expire_o
);
    localparam int PRE_W = $clog2(COARSE_RATIO > 1 ? COARSE_RATIO : 2);
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(COARSE_RATIO - 1);

    logic [PRE_W-1:0]  pre_q;
    logic [IVAL_W-1:0] cnt_q;
    logic              unit_step;

    assign unit_step = tick_i && (!coarse_i || pre_q == PRE_LAST);
    assign expire_o  = unit_step && (cnt_q == '0);

    // Prescaler: divide ticks into coarse units.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pre_q <= '0;
        else if (tick_i && coarse_i)
            pre_q <= (pre_q == PRE_LAST) ? '0 : pre_q + 1'b1;
    end

    // Unit counter: count down from ival, reload on expiry.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= ival_i;
        else if (unit_step)
            cnt_q <= (cnt_q == '0) ? ival_i : cnt_q - 1'b1;
    end

    a_r3_prescale_bound: assert property (@(posedge clk) disable iff (!rst_n)
        pre_q <= PRE_LAST);
endmodule

// File: rtl/burst_lfsr.sv
// Maximal-length Galois LFSR (right shift) for the repeat-gap delays.
// Loaded at reset from the seed input. A zero seed is replaced by a
// nonzero constant. It advances once per step_i.
module burst_lfsr
    import burst_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LFSR_W-1:0] seed_i,
    input  logic              step_i,
    output logic [LFSR_W-1:0] value_o
);
    logic [LFSR_W-1:0] q;

    // Seed at reset, then shift with feedback on each step.
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= (seed_i == '0) ? LFSR_ALT : seed_i;
        else if (step_i)
            q <= q[0] ? ((q >> 1) ^ LFSR_TAPS) : (q >> 1);
    end

    assign value_o = q;

    a_r5_lfsr_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        q != '0);
endmodule

// File: rtl/burst_sequencer.sv
// Burst sequencer. For each packet it requests conversions, waits for
// them, pulses a transmit start and waits for transmit-done. It then
// either ends the burst or waits a random gap before the next repeat.
// Expiries are queued in a pending flag.
module burst_sequencer
    import burst_pkg::*;
#(
    parameter int GAP_BITS = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                expire_i,
    input  logic                tick_i,
    input  logic [7:0]          cfg_i,
    input  logic [GAP_BITS-1:0] rnd_i,
    input  logic                adc_int_done_i,
    input  logic                adc_ext_done_i,
    input  logic                tx_done_i,
    output logic                step_o,
    output logic                adc_int_req_o,
    output logic                adc_ext_req_o,
    output logic                tx_start_o,
    output logic                pl_chip_id_o,
    output logic                pl_int_adc_o,
    output logic                pl_ext_adc_o
);
    localparam int CNT_W = GAP_BITS + 1;
    localparam logic [CNT_W-1:0] GAP_MAX = CNT_W'(2 ** GAP_BITS);

    seq_state_t       state_q;
    logic             pending_q;
    logic [REP_W-1:0] rem_q;
    logic [CNT_W-1:0] gap_q;
    logic             got_int_q, got_ext_q;
    logic             take, int_ok, ext_ok;

    assign take   = (state_q == S_IDLE) && pending_q;
    assign int_ok = !pl_int_adc_o || got_int_q || adc_int_done_i;
    assign ext_ok = !pl_ext_adc_o || got_ext_q || adc_ext_done_i;
    assign step_o = (state_q == S_TXW) && tx_done_i && (rem_q != '0);

    // Pending expiry: a new expiry wins over consumption in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pending_q <= 1'b0;
        else
            pending_q <= (pending_q && !take) || expire_i;
    end

    // Main sequence: conversions, start, wait for done, repeat gap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q      <= S_IDLE;
            rem_q        <= '0;
            gap_q        <= '0;
            got_int_q    <= 1'b0;
            got_ext_q    <= 1'b0;
            pl_chip_id_o <= 1'b0;
            pl_int_adc_o <= 1'b0;
            pl_ext_adc_o <= 1'b0;
        end else begin
            case (state_q)
                S_IDLE: if (pending_q) begin
                    state_q      <= S_ADC;
                    rem_q        <= cfg_i[CF_REP_LO +: REP_W];
                    pl_chip_id_o <= cfg_i[CF_ID];
                    pl_int_adc_o <= cfg_i[CF_INT];
                    pl_ext_adc_o <= cfg_i[CF_EXT];
                    got_int_q    <= 1'b0;
                    got_ext_q    <= 1'b0;
                end
                S_ADC: begin
                    got_int_q <= got_int_q || adc_int_done_i;
                    got_ext_q <= got_ext_q || adc_ext_done_i;
                    if (int_ok && ext_ok)
                        state_q <= S_START;
                end
                S_START: state_q <= S_TXW;
                S_TXW: if (tx_done_i) begin
                    if (rem_q == '0) begin
                        state_q <= S_IDLE;
                    end else begin
                        rem_q   <= rem_q - 1'b1;
                        gap_q   <= CNT_W'(rnd_i) + 1'b1;
                        state_q <= S_GAP;
                    end
                end
                S_GAP: if (tick_i) begin
                    if (gap_q == CNT_W'(1)) begin
                        state_q   <= S_ADC;
                        got_int_q <= 1'b0;
                        got_ext_q <= 1'b0;
                    end else begin
                        gap_q <= gap_q - 1'b1;
                    end
                end
                default: state_q <= S_IDLE;
            endcase
        end
    end

    assign adc_int_req_o = (state_q == S_ADC) && pl_int_adc_o && !got_int_q;
    assign adc_ext_req_o = (state_q == S_ADC) && pl_ext_adc_o && !got_ext_q;
    assign tx_start_o    = (state_q == S_START);

    a_r7_start_single: assert property (@(posedge clk) disable iff (!rst_n)
        tx_start_o |=> !tx_start_o);
    a_r6_wait_for_adc: assert property (@(posedge clk) disable iff (!rst_n)
        (adc_int_req_o && !adc_int_done_i) |=> !tx_start_o);
    a_r5_gap_range: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_GAP) |-> (gap_q != '0 && gap_q <= GAP_MAX));
    a_r4_rem_steps: assert property (@(posedge clk) disable iff (!rst_n)
        step_o |=> (rem_q == $past(rem_q) - 1'b1));
    a_r8_flags_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != S_IDLE) |=> $stable({pl_chip_id_o, pl_int_adc_o, pl_ext_adc_o}));
    a_r9_pending_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (expire_i && state_q != S_IDLE) |=> pending_q);
endmodule

// File: rtl/burst_scheduler.sv
// Top of the periodic burst scheduler. It connects the period timer,
// the ID-seeded LFSR and the burst sequencer. Assumes that all inputs
// are synchronous to clk and that the done inputs are single pulses.
module burst_scheduler
    import burst_pkg::*;
#(
    parameter int COARSE_RATIO = 300,
    parameter int IVAL_W       = 8,
    parameter int GAP_BITS     = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [7:0]        cfg_i,
    input  logic [IVAL_W-1:0] ival_i,
    input  logic [LFSR_W-1:0] chip_id_i,
    input  logic              tick_i,
    input  logic              adc_int_done_i,
    input  logic              adc_ext_done_i,
    input  logic              tx_done_i,
    output logic              adc_int_req_o,
    output logic              adc_ext_req_o,
    output logic              tx_start_o,
    output logic              pl_chip_id_o,
    output logic              pl_int_adc_o,
    output logic              pl_ext_adc_o
);
    logic              expire, step;
    logic [LFSR_W-1:0] rnd;

    burst_period_timer #(.COARSE_RATIO(COARSE_RATIO), .IVAL_W(IVAL_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .coarse_i(cfg_i[CF_RES]),
        .ival_i(ival_i), .expire_o(expire));

    burst_lfsr u_lfsr (
        .clk(clk), .rst_n(rst_n), .seed_i(chip_id_i), .step_i(step),
        .value_o(rnd));

    burst_sequencer #(.GAP_BITS(GAP_BITS)) u_seq (
        .clk(clk), .rst_n(rst_n), .expire_i(expire), .tick_i(tick_i),
        .cfg_i(cfg_i), .rnd_i(rnd[GAP_BITS-1:0]),
        .adc_int_done_i(adc_int_done_i), .adc_ext_done_i(adc_ext_done_i),
        .tx_done_i(tx_done_i), .step_o(step),
        .adc_int_req_o(adc_int_req_o), .adc_ext_req_o(adc_ext_req_o),
        .tx_start_o(tx_start_o), .pl_chip_id_o(pl_chip_id_o),
        .pl_int_adc_o(pl_int_adc_o), .pl_ext_adc_o(pl_ext_adc_o));

    a_r1_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
        tx_start_o |-> !(adc_int_req_o || adc_ext_req_o));
endmodule

// File: tb/test_burst_scheduler.sv
// Self-checking bench. A vector table is walked by one loop, followed by
// directed tests for reset, a zero interval and a pending burst.
module test_burst_scheduler;
    localparam int RATIO = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  cfg = '0, ival = '0;
    logic [15:0] chip = '0;
    logic        tick = 1'b0, dint = 1'b0, dext = 1'b0, txd = 1'b0;
    logic        rq_i, rq_e, st, f_id, f_int, f_ext;
    int          n_chk = 0, n_bad = 0;
    bit          finished = 0;

    always #5 clk = ~clk;

    burst_scheduler #(.COARSE_RATIO(RATIO)) i_burst_scheduler (
        .clk(clk), .rst_n(rst_n), .cfg_i(cfg), .ival_i(ival), .chip_id_i(chip),
        .tick_i(tick), .adc_int_done_i(dint), .adc_ext_done_i(dext), .tx_done_i(txd),
        .adc_int_req_o(rq_i), .adc_ext_req_o(rq_e), .tx_start_o(st),
        .pl_chip_id_o(f_id), .pl_int_adc_o(f_int), .pl_ext_adc_o(f_ext));

    // Fields of each row: cfg, ival, chip id, expected ticks to first burst.
    localparam logic [39:0] VEC [6] = '{
        {8'h00, 8'd60, 16'h0000, 8'd61},
        {8'h14, 8'd70, 16'h1234, 8'd71},
        {8'h2A, 8'd64, 16'hBEEF, 8'd65},
        {8'h3E, 8'd80, 16'h0007, 8'd81},
        {8'h01, 8'd20, 16'h8001, 8'd63},
        {8'h0D, 8'd25, 16'h00F0, 8'd78}
    };

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] lfsr_next(input logic [15:0] x);
        return x[0] ? ((x >> 1) ^ 16'hB400) : (x >> 1);
    endfunction

    task automatic do_reset();
        @(negedge clk) rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // One tick, then a 5-cycle window to watch for activity.
    task automatic tick_watch(output bit s, output bit ri, output bit re);
        @(negedge clk) tick = 1'b1;
        @(negedge clk) tick = 1'b0;
        s = st; ri = rq_i; re = rq_e;
        repeat (4) begin
            @(negedge clk);
            s |= st; ri |= rq_i; re |= rq_e;
        end
    endtask

    // Complete one transmission: serve the ADCs, find the start, send done.
    task automatic finish_tx(input logic [7:0] c, input bit started, input bit ri, input bit re);
        bit s = started;
        if (!s) begin
            bit early = 0;
            repeat (3) begin @(negedge clk); early |= st; end
            chk(!early, "R6 start before adc done", int'(early), 0);
            chk(rq_i == c[2] && rq_e == c[1], "R6 requests held",
                int'({rq_i, rq_e}), int'(c[2:1]));
            dint = c[2]; dext = c[1];
            @(negedge clk) begin dint = 1'b0; dext = 1'b0; end
            s = st;
            repeat (5) begin @(negedge clk); s |= st; end
        end
        chk(s, "R7 start pulse seen", int'(s), 1);
        chk({f_id, f_int, f_ext} == c[3:1], "R8 payload flags",
            int'({f_id, f_int, f_ext}), int'(c[3:1]));
        @(negedge clk) txd = 1'b1;
        @(negedge clk) txd = 1'b0;
    endtask

    task automatic run_row(input logic [39:0] v);
        logic [7:0] c = v[39:32];
        logic [7:0] nt = v[7:0];
        logic [15:0] m;
        bit s, ri, re, quiet;
        int starts;
        string tg;
        cfg = c; ival = v[31:24]; chip = v[23:8];
        m = (chip == 16'h0) ? 16'hACE1 : chip;
        tg = c[0] ? "R3 coarse period" : "R2 fine period";
        do_reset();
        quiet = 1;
        for (int k = 1; k < int'(nt); k++) begin
            tick_watch(s, ri, re);
            quiet &= !(s || ri || re);
        end
        chk(quiet, {tg, " early burst"}, int'(!quiet), 0);
        tick_watch(s, ri, re);
        chk((s || ri || re), {tg, " burst at end"}, int'(s || ri || re), 1);
        chk(ri == c[2] && re == c[1], "R6 request select", int'({ri, re}), int'(c[2:1]));
        starts = 1;
        finish_tx(c, s, ri, re);
        for (int r = 0; r < int'(c[5:4]); r++) begin
            int g = int'(m[3:0]) + 1;
            m = lfsr_next(m);
            quiet = 1;
            for (int j = 1; j < g; j++) begin
                tick_watch(s, ri, re);
                quiet &= !(s || ri || re);
            end
            chk(quiet, "R5 gap too short", g, g);
            tick_watch(s, ri, re);
            chk((s || ri || re), "R5 repeat after gap", int'(s || ri || re), 1);
            starts++;
            finish_tx(c, s, ri, re);
        end
        chk(starts == int'(c[5:4]) + 1, "R4 transmissions per burst", starts, int'(c[5:4]) + 1);
        s = 0;
        repeat (6) begin @(negedge clk); s |= st; end
        chk(!s, "R4 no extra start", int'(s), 0);
    endtask

    initial begin
        bit s, ri, re;
        // R1: reset state.
        cfg = 8'h3E; ival = 8'd5; chip = 16'h0042;
        do_reset();
        @(negedge clk);
        chk({st, rq_i, rq_e, f_id, f_int, f_ext} == 6'b0, "R1 reset outputs",
            int'({st, rq_i, rq_e, f_id, f_int, f_ext}), 0);
        tick_watch(s, ri, re);
        chk(!(s || ri || re), "R1 fresh period after reset", int'(s || ri || re), 0);

        foreach (VEC[i]) run_row(VEC[i]);

        // R2: interval 0 gives one tick. R9: pending burst. R7: ticks ignored.
        cfg = 8'h10; ival = 8'd0; chip = 16'h0005;
        do_reset();
        tick_watch(s, ri, re);
        chk(s, "R2 zero interval one tick", int'(s), 1);
        tick_watch(s, ri, re);
        chk(!s, "R7 tick while waiting for done", int'(s), 0);
        @(negedge clk) txd = 1'b1;
        @(negedge clk) txd = 1'b0;
        // First gap from seed 5: 6 ticks.
        for (int j = 1; j < 6; j++) begin
            tick_watch(s, ri, re);
            chk(!s, "R5 seeded gap", int'(s), 0);
        end
        tick_watch(s, ri, re);
        chk(s, "R5 repeat after seeded gap", int'(s), 1);
        @(negedge clk) txd = 1'b1;
        @(negedge clk) txd = 1'b0;
        s = 0;
        repeat (6) begin @(negedge clk); s |= st; end
        chk(s, "R9 pending burst starts without tick", int'(s), 1);

        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        finished = 1;
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end
endmodule